// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Acknowledge

This block models a set of device interrupt interfaces that share a single active-low request line toward a processor. Each device raises a request with a one-cycle pulse and holds it pending. The processor answers by asserting an acknowledge. That acknowledge enters the device nearest the processor and travels down the chain. A device with nothing pending passes it on. A device with a request pending stops it, drives its own identification code onto the shared data lines and drops its request on the following clock edge.

Priority comes only from position in the chain: the device at index 0 is nearest the processor and wins over every other. The shared data lines are modelled as a multiplexer that is steered by the per-device drive enables. On the processor side, a vector unit captures the code on every acknowledge cycle and forms the address of a service routine. The address is a fixed base with the code placed at bits 5:2. If an acknowledge reaches the end of the chain with no device claiming it, the data lines read zero and a spurious flag is raised.

Top module: `intr_daisy_chain`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are as follows: no device is pending, `irq_n_o` is 1, `bus_drive_o` is 0, `data_bus_o` is 0, `vec_addr_o` is 0x0100 and `spurious_o` is 0.
- R2: A 1 on `raise_i[k]` at a clock edge makes device k pending from that edge on. `irq_n_o` is 0 exactly while at least one device is pending.
- R3: While `ack_i` is 1 and some device is pending, exactly one bit of `bus_drive_o` is 1. That bit is the lowest-index pending device, and index 0 is nearest the processor.
- R4: A device that is not pending passes the acknowledge on, and a pending device blocks it. When several devices are pending, no device after the first pending one drives the bus.
- R5: During an acknowledge cycle, `data_bus_o` carries the code of the driving device in that same cycle. With the default parameters the codes are: device 0 = 0x3, device 1 = 0xA, device 2 = 0x5, device 3 = 0xC.
- R6: A device that drives the bus is no longer pending after that clock edge, unless it is raised again in the same cycle.
- R7: On the edge that ends an acknowledge cycle, `vec_addr_o` becomes 0x0100 OR (bus code << 2). It then holds its value through cycles with `ack_i` at 0.
- R8: An acknowledge with no device pending leaves `bus_drive_o` and `data_bus_o` at 0. On the next edge it sets `spurious_o` to 1 and `vec_addr_o` to 0x0100. An acknowledge that some device claims clears `spurious_o`.
- R9: A raise that arrives in the same cycle as that device's own claim keeps the device pending, so it is served again later.
- R10: When `ack_i` is held for several cycles, the pending devices are served one per cycle in chain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raise_i | input | 4 | One-cycle request pulse, one bit per device |
| ack_i | input | 1 | Processor acknowledge, which enters device 0 |
| irq_n_o | output | 1 | Shared active-low request line |
| bus_drive_o | output | 4 | Per-device data-line drive enables |
| data_bus_o | output | 4 | Shared data lines carrying the identification code |
| vec_addr_o | output | 16 | Formed service routine address |
| spurious_o | output | 1 | Last acknowledge was unclaimed |

## Verification
The hardest situation to reach is a device that claims the acknowledge in the very cycle it is raised again, while devices further down the chain are still waiting. The stimulus holds `ack_i` high across several cycles with all four devices pending. It then pulses that device's raise bit in its claim cycle and checks that the device is served a second time before the later devices. The walk down the chain under a held acknowledge, and the unclaimed acknowledge, come from the same table of cycles.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;
  localparam int DEF_N_DEV    = 4;
  localparam int DEF_CODE_W   = 4;
  localparam int DEF_ADDR_W   = 16;
  localparam int VEC_SHIFT    = 2;
  localparam logic [DEF_ADDR_W-1:0] DEF_VEC_BASE = 16'h0100;
  localparam logic [DEF_N_DEV*DEF_CODE_W-1:0] DEF_DEV_CODES = 16'hC5A3;
endpackage

// File: rtl/intr_rst_sync.sv
module intr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/intr_dev_stage.sv
module intr_dev_stage #(
  parameter int                CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_i,
  input  logic              ack_in_i,
  output logic              ack_out_o,
  output logic              drive_o,
  output logic              pend_o,
  output logic [CODE_W-1:0] code_o
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  // A pending device swallows the acknowledge; an idle one forwards it.
  always_comb begin
    drive_o   = ack_in_i & pend_q;
    ack_out_o = ack_in_i & ~pend_q;
    code_o    = CODE;
    pend_o    = pend_q;
  end

  // A raise wins over the release caused by its own claim.
  always_comb begin
    pend_en = raise_i | drive_o;
    pend_d  = raise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> pend_o); // R2
  AST_CLAIM_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && !raise_i) |=> !pend_o); // R6
  AST_RECLAIM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && raise_i) |=> pend_o); // R9
endmodule

// File: rtl/intr_bus_mux.sv
module intr_bus_mux #(
  parameter int N_DEV  = 4,
  parameter int CODE_W = 4
) (
  input  logic [N_DEV-1:0]        drive_i,
  input  logic [N_DEV*CODE_W-1:0] codes_i,
  output logic [CODE_W-1:0]       bus_o
);
  // Models the tristated data lines: only enabled drivers contribute.
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (drive_i[i]) begin
        bus_o = bus_o | codes_i[i*CODE_W +: CODE_W];
      end
    end
  end

  always_comb begin
    if (drive_i == '0) begin
      AST_IDLE_BUS_ZERO: assert (bus_o == '0); // R8
    end
  end
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit #(
  parameter int                CODE_W   = 4,
  parameter int                ADDR_W   = 16,
  parameter int                SHIFT    = 2,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              unclaimed_i,
  input  logic [CODE_W-1:0] bus_i,
  output logic [ADDR_W-1:0] vec_o,
  output logic              spur_o
);
  localparam int LOW_W = CODE_W + SHIFT;

  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] vec_d;
  logic              spur_q;
  logic              spur_d;
  logic              cap_en;

  always_comb begin
    cap_en = ack_i;
    vec_d  = {VEC_BASE[ADDR_W-1:LOW_W], bus_i, {SHIFT{1'b0}}};
    spur_d = unclaimed_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= VEC_BASE;
      spur_q <= 1'b0;
    end else if (cap_en) begin
      vec_q  <= vec_d;
      spur_q <= spur_d;
    end
  end

  assign vec_o  = vec_q;
  assign spur_o = spur_q;

  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vec_o)); // R7
  AST_SPUR_ON_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && unclaimed_i) |=> (spur_o && vec_o == VEC_BASE)); // R8
  AST_SPUR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !unclaimed_i) |=> !spur_o); // R8
endmodule

// File: rtl/intr_daisy_chain.sv
module intr_daisy_chain #(
  parameter int N_DEV  = intr_chain_pkg::DEF_N_DEV,
  parameter int CODE_W = intr_chain_pkg::DEF_CODE_W,
  parameter int ADDR_W = intr_chain_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]       VEC_BASE  = intr_chain_pkg::DEF_VEC_BASE,
  parameter logic [N_DEV*CODE_W-1:0] DEV_CODES = intr_chain_pkg::DEF_DEV_CODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DEV-1:0]  raise_i,
  input  logic              ack_i,
  output logic              irq_n_o,
  output logic [N_DEV-1:0]  bus_drive_o,
  output logic [CODE_W-1:0] data_bus_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              spurious_o
);
  logic                    rst_n_int;
  logic [N_DEV:0]          ack_link;
  logic [N_DEV-1:0]        drive;
  logic [N_DEV-1:0]        pend;
  logic [N_DEV*CODE_W-1:0] codes;

  intr_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign ack_link[0] = ack_i;

  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    intr_dev_stage #(
      .CODE_W (CODE_W),
      .CODE   (DEV_CODES[k*CODE_W +: CODE_W])
    ) i_stage (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .raise_i   (raise_i[k]),
      .ack_in_i  (ack_link[k]),
      .ack_out_o (ack_link[k+1]),
      .drive_o   (drive[k]),
      .pend_o    (pend[k]),
      .code_o    (codes[k*CODE_W +: CODE_W])
    );

    localparam logic [N_DEV-1:0] NEARER = N_DEV'((1 << k) - 1);
    AST_CHAIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n_int)
      drive[k] |-> ((pend & NEARER) == '0)); // R3
  end

  intr_bus_mux #(
    .N_DEV  (N_DEV),
    .CODE_W (CODE_W)
  ) i_bus_mux (
    .drive_i (drive),
    .codes_i (codes),
    .bus_o   (data_bus_o)
  );

  // The acknowledge leaving the last device means nobody took it.
  intr_vector_unit #(
    .CODE_W   (CODE_W),
    .ADDR_W   (ADDR_W),
    .SHIFT    (intr_chain_pkg::VEC_SHIFT),
    .VEC_BASE (VEC_BASE)
  ) i_vector (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .ack_i       (ack_i),
    .unclaimed_i (ack_link[N_DEV]),
    .bus_i       (data_bus_o),
    .vec_o       (vec_addr_o),
    .spur_o      (spurious_o)
  );

  assign irq_n_o     = ~(|pend);
  assign bus_drive_o = drive;

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|bus_drive_o) |-> ($countones(bus_drive_o) == 1)); // R3
  AST_PENDING_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ack_i && !irq_n_o) |-> ($countones(bus_drive_o) == 1)); // R4
  AST_NO_ACK_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!ack_i || irq_n_o) |-> (bus_drive_o == '0)); // R4
endmodule

// File: tb/test_intr_daisy_chain.sv
module test_intr_daisy_chain;
  logic        clk;
  logic        rst_n;
  logic [3:0]  raise;
  logic        ack;
  logic        irq_n;
  logic [3:0]  drv;
  logic [3:0]  bus;
  logic [15:0] vec;
  logic        spur;

  int checks = 0;
  int fails  = 0;

  intr_daisy_chain i_intr_daisy_chain (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_i     (raise),
    .ack_i       (ack),
    .irq_n_o     (irq_n),
    .bus_drive_o (drv),
    .data_bus_o  (bus),
    .vec_addr_o  (vec),
    .spurious_o  (spur)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  raise;
    logic        ack;
    logic        irq_n;
    logic [3:0]  drive;
    logic [3:0]  bus;
    logic [15:0] vec;
    logic        spur;
  } row_t;

  localparam int NROWS = 16;
  // irq_n, drive and bus are sampled before the edge; vec and spur after it.
  localparam row_t ROWS [NROWS] = '{
    '{4'b0000, 1'b0, 1'b1, 4'b0000, 4'h0, 16'h0100, 1'b0}, // idle
    '{4'b0100, 1'b0, 1'b1, 4'b0000, 4'h0, 16'h0100, 1'b0}, // R2 raise dev2
    '{4'b0000, 1'b0, 1'b0, 4'b0000, 4'h0, 16'h0100, 1'b0}, // R2 line low
    '{4'b0000, 1'b1, 1'b0, 4'b0100, 4'h5, 16'h0114, 1'b0}, // R3 R5 R7
    '{4'b1010, 1'b0, 1'b1, 4'b0000, 4'h0, 16'h0114, 1'b0}, // R6 released
    '{4'b0000, 1'b1, 1'b0, 4'b0010, 4'hA, 16'h0128, 1'b0}, // R4 dev1 blocks dev3
    '{4'b0001, 1'b1, 1'b0, 4'b1000, 4'hC, 16'h0130, 1'b0}, // dev3 served
    '{4'b0000, 1'b1, 1'b0, 4'b0001, 4'h3, 16'h010C, 1'b0}, // dev0 served
    '{4'b0000, 1'b1, 1'b1, 4'b0000, 4'h0, 16'h0100, 1'b1}, // R8 unclaimed
    '{4'b1111, 1'b0, 1'b1, 4'b0000, 4'h0, 16'h0100, 1'b1}, // R7 R8 hold
    '{4'b0000, 1'b1, 1'b0, 4'b0001, 4'h3, 16'h010C, 1'b0}, // R10 held ack
    '{4'b0000, 1'b1, 1'b0, 4'b0010, 4'hA, 16'h0128, 1'b0}, // R10
    '{4'b0100, 1'b1, 1'b0, 4'b0100, 4'h5, 16'h0114, 1'b0}, // R9 re-raise
    '{4'b0000, 1'b1, 1'b0, 4'b0100, 4'h5, 16'h0114, 1'b0}, // R9 served again
    '{4'b0000, 1'b1, 1'b0, 4'b1000, 4'hC, 16'h0130, 1'b0}, // R10 last
    '{4'b0000, 1'b0, 1'b1, 4'b0000, 4'h0, 16'h0130, 1'b0}  // R6 all released
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    raise = '0;
    ack   = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state while reset is held
    check("R1 irq_n in reset", 32'(irq_n), 32'h1);
    check("R1 vec in reset", 32'(vec), 32'h0100);
    check("R1 spur in reset", 32'(spur), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 drive after reset", 32'(drv), 32'h0);
    check("R1 bus after reset", 32'(bus), 32'h0);

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      raise = ROWS[r].raise;
      ack   = ROWS[r].ack;
      #2;
      check($sformatf("R2/R6 irq_n row %0d", r), 32'(irq_n), 32'(ROWS[r].irq_n));
      check($sformatf("R3/R4 drive row %0d", r), 32'(drv), 32'(ROWS[r].drive));
      check($sformatf("R5 bus row %0d", r), 32'(bus), 32'(ROWS[r].bus));
      @(posedge clk);
      #2;
      check($sformatf("R7 vec row %0d", r), 32'(vec), 32'(ROWS[r].vec));
      check($sformatf("R8 spur row %0d", r), 32'(spur), 32'(ROWS[r].spur));
    end

    // R1: reset in the middle of activity clears pending and vector state
    @(negedge clk);
    raise = 4'b0011;
    ack   = 1'b0;
    @(negedge clk);
    raise = '0;
    ack   = 1'b1;
    #2;
    check("R3 dev0 wins over dev1", 32'(drv), 32'h1);
    rst_n = 1'b0;
    #2;
    check("R1 irq_n async reset", 32'(irq_n), 32'h1);
    check("R1 vec async reset", 32'(vec), 32'h0100);
    ack = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    ack = 1'b1;
    #2;
    check("R8 unclaimed ack after reset drive", 32'(drv), 32'h0);
    @(posedge clk);
    #2;
    check("R8 spur after unclaimed", 32'(spur), 32'h1);
    @(negedge clk) ack = 1'b0;

    summary();
    $finish;
  end
endmodule